// File: doc/BRIEF.md
# Register Rename Status Table

This block holds, for every architectural register of an out-of-order core, the last committed value, a pending flag, and the tag of the reorder-buffer slot that will produce the register's next value. At issue, two source registers are looked up through combinational read ports. Each lookup gives the value, the pending flag and the producer tag, so the issue logic can take either a ready operand or a tag to wait on. The same cycle can claim a destination register for a newly allocated buffer slot.

When the reorder buffer retires an entry, it sends the destination, the entry's tag and the result. The result always becomes the committed value. The pending flag drops only when the retiring tag is still the register's newest producer. A younger writer that is still in flight keeps the register pending.

A misprediction flush wipes every pending flag and producer tag in one cycle and keeps the committed values. A parameter can fix register zero to a constant zero that never becomes pending.

Top module: `rename_status_table`

## Requirements
- R1: After reset, every register reads value 0, pending 0 and tag 0.
- R2: Both read ports are combinational and independent. Each returns the value, pending flag and tag of the register selected by its own index in the same cycle.
- R3: An issue with `issueEn` high and no flush sets the destination's pending flag to 1 and its tag to `issueTag`, both visible from the cycle after the edge.
- R4: A commit with `commitEn` high writes `commitVal` into the destination's value, whatever the tag and pending state. The value is visible from the cycle after the edge.
- R5: A commit whose `commitTag` equals the destination's current tag, while that register is pending, clears the pending flag. The tag field keeps its old contents.
- R6: A commit whose `commitTag` differs from the destination's current tag leaves the pending flag and tag unchanged.
- R7: When an issue and a commit name the same register in one cycle, the issue wins. The register ends pending with the new issue tag, and the commit value is still written.
- R8: `flush` clears the pending flag and sets the tag to 0 for all registers, and leaves every value unchanged. An issue in the flush cycle has no effect.
- R9: With `ZERO_REG`=1, register 0 always reads value 0, pending 0 and tag 0. Issues and commits aimed at it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Misprediction flush of all pending state |
| issueEn | input | 1 | Claim a destination register at issue |
| issueDst | input | IDX_W | Destination register index |
| issueTag | input | TAG_W | Reorder-buffer slot allocated to the issue |
| commitEn | input | 1 | Retire an entry into the table |
| commitDst | input | IDX_W | Destination of the retiring entry |
| commitTag | input | TAG_W | Slot index of the retiring entry |
| commitVal | input | DATA_W | Result of the retiring entry |
| src1Idx | input | IDX_W | Read port 1 register index |
| src1Val | output | DATA_W | Read port 1 committed value |
| src1Busy | output | 1 | Read port 1 pending flag |
| src1Tag | output | TAG_W | Read port 1 producer tag |
| src2Idx | input | IDX_W | Read port 2 register index |
| src2Val | output | DATA_W | Read port 2 committed value |
| src2Busy | output | 1 | Read port 2 pending flag |
| src2Tag | output | TAG_W | Read port 2 producer tag |

## Verification
The hardest cases to reach are those where ownership has moved on. One is a retirement from an older slot after a younger slot has claimed the same register. The other is a retirement that lands in the same cycle as a fresh claim. The stimulus table sets these up in order: two claims on one register, then retirement of the older tag, then the younger. A second register receives a claim and a matching retirement on the same edge. Flush coverage places a claim in the flush cycle, then reads back both the flushed register and the register claimed during the flush.

// File: rtl/renstat_pkg.sv
package renstat_pkg;
  // Strobes from control to datapath, one per kind of update.
  typedef struct packed {
    logic doIssue;     // claim issueDst with issueTag
    logic doCommitVal; // write commitVal into commitDst
    logic doCommitClr; // drop pending flag of commitDst
    logic doFlush;     // clear all pending flags and tags
  } ctrlStrobes_t;
endpackage

// File: rtl/renstat_ctrl.sv
module renstat_ctrl
  import renstat_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 4,
  parameter bit ZERO_REG = 1'b1,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             flush,
  input  logic             issueEn,
  input  logic [IDX_W-1:0] issueDst,
  input  logic             commitEn,
  input  logic [IDX_W-1:0] commitDst,
  input  logic             commitOwner,
  output ctrlStrobes_t     strb
);
  logic issueToZero;
  logic commitToZero;
  logic sameReg;

  always_comb begin
    issueToZero  = ZERO_REG && (issueDst == '0);
    commitToZero = ZERO_REG && (commitDst == '0);
    sameReg      = (issueDst == commitDst);

    strb.doFlush     = flush;
    strb.doIssue     = issueEn && !flush && !issueToZero;
    strb.doCommitVal = commitEn && !commitToZero;
    // A claim on the same register in this cycle outranks the clear.
    strb.doCommitClr = commitEn && !commitToZero && !flush && commitOwner
                       && !(strb.doIssue && sameReg);
  end
endmodule

// File: rtl/renstat_datapath.sv
module renstat_datapath
  import renstat_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter bit ZERO_REG = 1'b1,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [IDX_W-1:0]  issueDst,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic [IDX_W-1:0]  commitDst,
  input  logic [TAG_W-1:0]  commitTag,
  input  logic [DATA_W-1:0] commitVal,
  input  logic [IDX_W-1:0]  src1Idx,
  input  logic [IDX_W-1:0]  src2Idx,
  output logic [DATA_W-1:0] src1Val,
  output logic              src1Busy,
  output logic [TAG_W-1:0]  src1Tag,
  output logic [DATA_W-1:0] src2Val,
  output logic              src2Busy,
  output logic [TAG_W-1:0]  src2Tag,
  output logic              commitOwner
);
  logic [DATA_W-1:0] valArr  [NUM_REGS];
  logic              busyArr [NUM_REGS];
  logic [TAG_W-1:0]  tagArr  [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : gCell
    if (ZERO_REG && r == 0) begin : gZero
      assign valArr[r]  = '0;
      assign busyArr[r] = 1'b0;
      assign tagArr[r]  = '0;
    end else begin : gLive
      logic [DATA_W-1:0] valQ;
      logic              busyQ;
      logic [TAG_W-1:0]  tagQ;
      logic              hitIssue;
      logic              hitCommit;

      assign hitIssue  = strb.doIssue && (issueDst == IDX_W'(r));
      assign hitCommit = (commitDst == IDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valQ <= '0;
        end else if (strb.doCommitVal && hitCommit) begin
          valQ <= commitVal;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busyQ <= 1'b0;
          tagQ  <= '0;
        end else if (strb.doFlush) begin
          busyQ <= 1'b0;
          tagQ  <= '0;
        end else if (hitIssue) begin
          busyQ <= 1'b1;
          tagQ  <= issueTag;
        end else if (strb.doCommitClr && hitCommit) begin
          busyQ <= 1'b0;
        end
      end

      assign valArr[r]  = valQ;
      assign busyArr[r] = busyQ;
      assign tagArr[r]  = tagQ;
    end
  end

  always_comb begin
    src1Val     = valArr[src1Idx];
    src1Busy    = busyArr[src1Idx];
    src1Tag     = tagArr[src1Idx];
    src2Val     = valArr[src2Idx];
    src2Busy    = busyArr[src2Idx];
    src2Tag     = tagArr[src2Idx];
    commitOwner = busyArr[commitDst] && (tagArr[commitDst] == commitTag);
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import renstat_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter bit ZERO_REG = 1'b1,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              issueEn,
  input  logic [IDX_W-1:0]  issueDst,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic              commitEn,
  input  logic [IDX_W-1:0]  commitDst,
  input  logic [TAG_W-1:0]  commitTag,
  input  logic [DATA_W-1:0] commitVal,
  input  logic [IDX_W-1:0]  src1Idx,
  output logic [DATA_W-1:0] src1Val,
  output logic              src1Busy,
  output logic [TAG_W-1:0]  src1Tag,
  input  logic [IDX_W-1:0]  src2Idx,
  output logic [DATA_W-1:0] src2Val,
  output logic              src2Busy,
  output logic [TAG_W-1:0]  src2Tag
);
  ctrlStrobes_t strb;
  logic         commitOwner;

  renstat_ctrl #(
    .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .ZERO_REG(ZERO_REG)
  ) u_ctrl (
    .flush(flush), .issueEn(issueEn), .issueDst(issueDst),
    .commitEn(commitEn), .commitDst(commitDst),
    .commitOwner(commitOwner), .strb(strb)
  );

  renstat_datapath #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .ZERO_REG(ZERO_REG)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .issueDst(issueDst), .issueTag(issueTag),
    .commitDst(commitDst), .commitTag(commitTag), .commitVal(commitVal),
    .src1Idx(src1Idx), .src2Idx(src2Idx),
    .src1Val(src1Val), .src1Busy(src1Busy), .src1Tag(src1Tag),
    .src2Val(src2Val), .src2Busy(src2Busy), .src2Tag(src2Tag),
    .commitOwner(commitOwner)
  );
endmodule

// File: rtl/renstat_chk.sv
module renstat_chk #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter bit ZERO_REG = 1'b1,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              issueEn,
  input logic [IDX_W-1:0]  issueDst,
  input logic [TAG_W-1:0]  issueTag,
  input logic              commitEn,
  input logic [IDX_W-1:0]  commitDst,
  input logic [TAG_W-1:0]  commitTag,
  input logic [DATA_W-1:0] commitVal,
  input logic [IDX_W-1:0]  src1Idx,
  input logic [DATA_W-1:0] src1Val,
  input logic              src1Busy,
  input logic [TAG_W-1:0]  src1Tag,
  input logic [IDX_W-1:0]  src2Idx,
  input logic              src2Busy
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_ISSUE_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(issueEn && !flush && !(ZERO_REG && issueDst == '0))
      && src1Idx == $past(issueDst)
    |-> src1Busy && src1Tag == $past(issueTag)); // R3 R7

  AST_COMMIT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(commitEn && !(ZERO_REG && commitDst == '0))
      && src1Idx == $past(commitDst)
    |-> src1Val == $past(commitVal)); // R4

  AST_OWNER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(commitEn && !flush && src1Idx == commitDst && src1Busy
      && src1Tag == commitTag && !(issueEn && issueDst == commitDst))
      && src1Idx == $past(src1Idx)
    |-> !src1Busy); // R5

  AST_STALE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(commitEn && !flush && !issueEn && src1Idx == commitDst
      && src1Busy && src1Tag != commitTag)
      && src1Idx == $past(src1Idx)
    |-> src1Busy && $stable(src1Tag)); // R6

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(flush) |-> !src1Busy && !src2Busy && src1Tag == '0); // R8

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (ZERO_REG && src1Idx == '0) |-> src1Val == '0 && !src1Busy); // R9
endmodule

bind rename_status_table renstat_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .ZERO_REG(ZERO_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .issueEn(issueEn), .issueDst(issueDst), .issueTag(issueTag),
  .commitEn(commitEn), .commitDst(commitDst), .commitTag(commitTag),
  .commitVal(commitVal),
  .src1Idx(src1Idx), .src1Val(src1Val), .src1Busy(src1Busy), .src1Tag(src1Tag),
  .src2Idx(src2Idx), .src2Busy(src2Busy)
);

// File: tb/tb_rename_status_table.sv
module tb_rename_status_table;
  localparam int NUM_REGS = 32;
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              issueEn = 1'b0;
  logic [IDX_W-1:0]  issueDst = '0;
  logic [TAG_W-1:0]  issueTag = '0;
  logic              commitEn = 1'b0;
  logic [IDX_W-1:0]  commitDst = '0;
  logic [TAG_W-1:0]  commitTag = '0;
  logic [DATA_W-1:0] commitVal = '0;
  logic [IDX_W-1:0]  src1Idx = '0;
  logic [IDX_W-1:0]  src2Idx = '0;
  logic [DATA_W-1:0] src1Val, src2Val;
  logic              src1Busy, src2Busy;
  logic [TAG_W-1:0]  src1Tag, src2Tag;

  int total = 0;
  int failed = 0;

  always #10 clk = ~clk; // 50 MHz

  rename_status_table #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .ZERO_REG(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .issueEn(issueEn), .issueDst(issueDst), .issueTag(issueTag),
    .commitEn(commitEn), .commitDst(commitDst), .commitTag(commitTag),
    .commitVal(commitVal),
    .src1Idx(src1Idx), .src1Val(src1Val), .src1Busy(src1Busy), .src1Tag(src1Tag),
    .src2Idx(src2Idx), .src2Val(src2Val), .src2Busy(src2Busy), .src2Tag(src2Tag)
  );

  typedef struct packed {
    logic [3:0]        req;
    logic              iEn;
    logic [IDX_W-1:0]  iDst;
    logic [TAG_W-1:0]  iTag;
    logic              cEn;
    logic [IDX_W-1:0]  cDst;
    logic [TAG_W-1:0]  cTag;
    logic [DATA_W-1:0] cVal;
    logic              fl;
    logic [IDX_W-1:0]  probe;
    logic              eBusy;
    logic [TAG_W-1:0]  eTag;
    logic [DATA_W-1:0] eVal;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3, 1,  5, 3, 0,  0, 0, 32'h0,      0,  5, 1, 3, 32'h0},       // R3 claim r5
    '{3, 1,  5, 7, 0,  0, 0, 32'h0,      0,  5, 1, 7, 32'h0},       // R3 younger claim
    '{6, 0,  0, 0, 1,  5, 3, 32'hAAAA,   0,  5, 1, 7, 32'hAAAA},    // R6 stale retire
    '{5, 0,  0, 0, 1,  5, 7, 32'hBBBB,   0,  5, 0, 7, 32'hBBBB},    // R5 owner retire
    '{3, 1,  9, 2, 0,  0, 0, 32'h0,      0,  9, 1, 2, 32'h0},       // R3 claim r9
    '{7, 1,  9, 4, 1,  9, 2, 32'h1234,   0,  9, 1, 4, 32'h1234},    // R7 claim+retire
    '{5, 0,  0, 0, 1,  9, 4, 32'h55,     0,  9, 0, 4, 32'h55},      // R5 retire r9
    '{3, 1, 12, 1, 0,  0, 0, 32'h0,      0, 12, 1, 1, 32'h0},       // R3 claim r12
    '{8, 1, 13, 6, 0,  0, 0, 32'h0,      1, 12, 0, 0, 32'h0},       // R8 flush
    '{8, 0,  0, 0, 0,  0, 0, 32'h0,      0, 13, 0, 0, 32'h0},       // R8 claim ignored
    '{9, 1,  0, 5, 0,  0, 0, 32'h0,      0,  0, 0, 0, 32'h0},       // R9 claim r0
    '{9, 0,  0, 0, 1,  0, 5, 32'hFFFF,   0,  0, 0, 0, 32'h0},       // R9 retire r0
    '{4, 0,  0, 0, 1, 31, 0, 32'hCAFE,   0, 31, 0, 0, 32'hCAFE}     // R4 idle reg
  };

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    issueEn = 1'b0; commitEn = 1'b0; flush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    src1Idx = 5; src2Idx = 17;
    #2;
    chk("R1 busy", {31'd0, src1Busy}, 32'd0);
    chk("R1 tag",  {28'd0, src2Tag},  32'd0);
    chk("R1 val",  src2Val,           32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      issueEn = VECS[i].iEn; issueDst = VECS[i].iDst; issueTag = VECS[i].iTag;
      commitEn = VECS[i].cEn; commitDst = VECS[i].cDst; commitTag = VECS[i].cTag;
      commitVal = VECS[i].cVal; flush = VECS[i].fl;
      @(negedge clk);
      idle();
      src1Idx = VECS[i].probe;
      #2;
      chk($sformatf("R%0d busy step %0d", VECS[i].req, i),
          {31'd0, src1Busy}, {31'd0, VECS[i].eBusy});
      chk($sformatf("R%0d tag step %0d", VECS[i].req, i),
          {28'd0, src1Tag}, {28'd0, VECS[i].eTag});
      chk($sformatf("R%0d val step %0d", VECS[i].req, i),
          src1Val, VECS[i].eVal);
    end

    // R2: both ports read different registers in the same cycle
    src1Idx = 5; src2Idx = 31;
    #2;
    chk("R2 port1 val", src1Val, 32'hBBBB);
    chk("R2 port2 val", src2Val, 32'hCAFE);
    src2Idx = 9;
    #1;
    chk("R2 port2 comb", src2Val, 32'h55);

    // R8: flush keeps committed values, clears pending of a live claim
    @(negedge clk);
    issueEn = 1'b1; issueDst = 5; issueTag = 9;
    @(negedge clk);
    idle(); flush = 1'b1;
    @(negedge clk);
    idle();
    src1Idx = 5; src2Idx = 5;
    #2;
    chk("R8 value kept", src1Val, 32'hBBBB);
    chk("R8 busy cleared", {31'd0, src2Busy}, 32'd0);
    chk("R8 tag cleared", {28'd0, src2Tag}, 32'd0);

    // R1: reset mid-run returns values to zero
    rst_n = 1'b0;
    #2;
    chk("R1 reset val", src1Val, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule